// File: doc/BRIEF.md
# Memory Deposit-Examine Pattern Tester

This block exercises a small word-organised memory through a plain write/read port and reports whether every word held what was written. It runs five data blocks in a fixed order. For each block it first deposits every word of the block into consecutive addresses starting at zero, one word per cycle. It then returns the address to zero and examines the same words one per cycle, comparing each returned word with the value it deposited.

Four of the blocks are bit-pattern sequences that expose stuck or shorted data lines: a single one walking left, a single zero walking left, ones filling in from the right, and zeros filling in from the right. Each of these sequences is bracketed by a repeat of its background value. The last block is an address test: every word of the memory receives the Gray code of its own address, so neighbouring words differ in one bit and an address line that is stuck or aliased shows up as a wrong word.

The first mismatch is recorded (address, expected word, returned word) and raises a sticky fail flag. The run always continues to the end and then raises done, which stays up until the next start.

Top module: `memtest_top`

## Requirements
- R1: While reset is held, done, fail, mem_we and mem_re are 0 and the recorded address, expected and returned words are 0.
- R2: The first block is 14 words: index 0 holds 0, index i in 1..12 holds 2^(i-1), index 13 holds 0 (12-bit words).
- R3: The second block is 14 words, each the bitwise complement of the matching first-block word.
- R4: The third block is 14 words: index 0 holds 0, index i in 1..12 holds 2^i - 1, index 13 holds 0.
- R5: The fourth block is 14 words, each the bitwise complement of the matching third-block word.
- R6: The fifth block covers all 16 addresses, address a receiving a XOR (a >> 1).
- R7: Within a block, all writes come first on consecutive cycles at addresses 0, 1, 2, ...; the reads follow at addresses 0, 1, 2, ...; mem_we and mem_re are never high in the same cycle.
- R8: The word on mem_rdata in the cycle after a read strobe is the one compared against the word deposited at that read's address.
- R9: The first mismatching read sets fail and records its address, expected word and returned word; later mismatches change none of them, and the run still completes all five blocks.
- R10: done rises exactly 149 clock edges after the edge that samples start (2L+1 edges for each block of length L), stays high until the next start, and a start pulse while a run is in progress has no effect.
- R11: A start accepted while idle or done clears fail and the recorded result at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle or done |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_addr | output | 4 | Word address for the current strobe |
| mem_wdata | output | 12 | Word to write |
| mem_rdata | input | 12 | Word returned one cycle after mem_re |
| done | output | 1 | Run complete |
| fail | output | 1 | At least one mismatch seen in this run |
| fail_addr | output | 4 | Address of the first mismatch |
| fail_exp | output | 12 | Expected word at the first mismatch |
| fail_got | output | 12 | Returned word at the first mismatch |

## Verification
The assertions take for granted that the attached memory returns the addressed word exactly one cycle after a read strobe and that reset is synchronous, so the compare pipeline and fail latch only have to hold against that timing. The bench's memory model keeps to this latency in every run and injects faults only in the stored or returned data (stuck-at bits on read, a dropped address bit on write), never in the timing. Start is driven away from the clock edge, including one pulse deliberately placed inside a run, so the ignored-start rule is exercised without racing the sequencer.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    typedef enum logic [2:0] {
        PH_WALK1 = 3'd0,
        PH_WALK0 = 3'd1,
        PH_FILL1 = 3'd2,
        PH_FILL0 = 3'd3,
        PH_GRAY  = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_READ  = 3'd2,
        ST_TAIL  = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

    function automatic phase_e next_phase(phase_e ph);
        return phase_e'(ph + 3'd1);
    endfunction

endpackage

// File: rtl/memtest_patgen.sv
module memtest_patgen
    import memtest_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 4
) (
    input  phase_e              phase,
    input  logic [ADDR_W-1:0]   idx,
    output logic [DATA_W-1:0]   word
);
    localparam logic [DATA_W-1:0] ALL1 = '1;
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

    logic              inner;
    logic [DATA_W-1:0] walk;
    logic [DATA_W-1:0] fill;
    logic [DATA_W-1:0] gray;

    always_comb begin
        inner = (idx != '0) && (int'(idx) <= DATA_W);
        walk  = inner ? (ONE << (idx - 1'b1)) : '0;
        fill  = inner ? ~(ALL1 << idx) : '0;
        gray  = DATA_W'(idx ^ (idx >> 1));
        case (phase)
            PH_WALK1: word = walk;
            PH_WALK0: word = ~walk;
            PH_FILL1: word = fill;
            PH_FILL0: word = ~fill;
            default:  word = gray;
        endcase
    end
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
    import memtest_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output phase_e            phase,
    output logic [ADDR_W-1:0] idx,
    output logic              we,
    output logic              re,
    output logic              rd_pend,
    output logic [ADDR_W-1:0] rd_idx,
    output logic              clear,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST_WALK = ADDR_W'(DATA_W + 1);
    localparam logic [ADDR_W-1:0] LAST_GRAY = ADDR_W'(DEPTH - 1);

    state_e            state;
    logic [ADDR_W-1:0] last_idx;
    logic              at_last;

    always_comb begin
        last_idx = (phase == PH_GRAY) ? LAST_GRAY : LAST_WALK;
        at_last  = (idx == last_idx);
        we       = (state == ST_WRITE);
        re       = (state == ST_READ);
        done     = (state == ST_DONE);
        clear    = start && ((state == ST_IDLE) || (state == ST_DONE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_WALK1;
            idx     <= '0;
            rd_pend <= 1'b0;
            rd_idx  <= '0;
        end else begin
            rd_pend <= (state == ST_READ);
            rd_idx  <= idx;
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state <= ST_WRITE;
                        phase <= PH_WALK1;
                        idx   <= '0;
                    end
                end
                ST_WRITE: begin
                    if (at_last) begin
                        idx   <= '0;
                        state <= ST_READ;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_READ: begin
                    if (at_last) begin
                        idx   <= '0;
                        state <= ST_TAIL;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (phase == PH_GRAY) begin
                        state <= ST_DONE;
                    end else begin
                        phase <= next_phase(phase);
                        state <= ST_WRITE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: write and read strobes never overlap
    a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(we && re));

    // R7: back-to-back writes step the address by one
    a_r7_write_step: assert property (@(posedge clk) disable iff (rst)
        we |=> (!we || idx == $past(idx) + 1'b1));

    // R7: back-to-back reads step the address by one
    a_r7_read_step: assert property (@(posedge clk) disable iff (rst)
        re |=> (!re || idx == $past(idx) + 1'b1));

    // R7: the read pass of a block begins at address zero
    a_r7_read_from_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(re) |-> (idx == '0));

    // R10: done holds until a new start
    a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R10: start during a run leaves the block in progress
    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && start && !at_last) |=> (we && $stable(phase)));
endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              chk,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [DATA_W-1:0] exp_word,
    input  logic [DATA_W-1:0] got_word,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    logic mismatch;
    assign mismatch = chk && (got_word != exp_word);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= chk_addr;
            fail_exp  <= exp_word;
            fail_got  <= got_word;
        end
    end

    // R9: fail is sticky until a new run clears it
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> fail);

    // R9: the first record is frozen once taken
    a_r9_record_frozen: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_got)));

    // R9: a checked mismatch always leaves fail set
    a_r9_mismatch_flags: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !clear) |=> fail);

    // R11: an accepted start clears the result
    a_r11_clear_result: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!fail && fail_addr == '0));
endmodule

// File: rtl/memtest_top.sv
module memtest_top
    import memtest_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    phase_e            phase;
    logic [ADDR_W-1:0] idx;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_idx;
    logic              clear;
    logic [DATA_W-1:0] exp_word;

    memtest_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phase   (phase),
        .idx     (idx),
        .we      (mem_we),
        .re      (mem_re),
        .rd_pend (rd_pend),
        .rd_idx  (rd_idx),
        .clear   (clear),
        .done    (done)
    );

    memtest_patgen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr_pat (
        .phase (phase),
        .idx   (idx),
        .word  (mem_wdata)
    );

    memtest_patgen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_pat (
        .phase (phase),
        .idx   (rd_idx),
        .word  (exp_word)
    );

    memtest_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .chk       (rd_pend),
        .chk_addr  (rd_idx),
        .exp_word  (exp_word),
        .got_word  (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_got  (fail_got)
    );

    assign mem_addr = idx;

    // R1: no strobe while reset holds the block
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!mem_we && !mem_re && !done));
endmodule

// File: tb/memtest_top_bench.sv
module memtest_top_bench;
    localparam int DW = 12;
    localparam int DP = 16;
    localparam int AW = 4;
    localparam int RUN_EDGES = 4 * (2 * 14 + 1) + (2 * 16 + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mem_we, mem_re, done, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata, fail_exp, fail_got;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] mem [DP];
    logic [DW-1:0] s1 = '0, s0 = '0;
    logic [AW-1:0] am = '0;
    logic          logclr = 1'b0;
    int            wn = 0, rn = 0;
    logic [AW-1:0] wa [100];
    logic [DW-1:0] wd [100];
    logic [AW-1:0] ra [100];

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    memtest_top u_memtest_top (
        .clk(clk), .rst(rst), .start(start),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_got(fail_got)
    );

    initial for (int i = 0; i < DP; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr & ~am] <= mem_wdata;
        if (mem_re) mem_rdata <= (mem[mem_addr] | s1) & ~s0;
        if (logclr) begin
            wn <= 0;
            rn <= 0;
        end else begin
            if (mem_we && wn < 100) begin
                wa[wn] <= mem_addr;
                wd[wn] <= mem_wdata;
                wn <= wn + 1;
            end
            if (mem_re && rn < 100) begin
                ra[rn] <= mem_addr;
                rn <= rn + 1;
            end
        end
    end

    function automatic int blen(int ph);
        return (ph == 4) ? 16 : 14;
    endfunction

    function automatic logic [DW-1:0] ew(int ph, int i);
        int w1, f1;
        w1 = (i >= 1 && i <= 12) ? (1 << (i - 1)) : 0;
        f1 = (i >= 1 && i <= 12) ? ((1 << i) - 1) : 0;
        case (ph)
            0: return DW'(w1);
            1: return DW'(4095 - w1);
            2: return DW'(f1);
            3: return DW'(4095 - f1);
            default: return DW'(i ^ (i >> 1));
        endcase
    endfunction

    function automatic string ptag(int ph);
        case (ph)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model of the whole run against the faulty memory
    task automatic predict(output bit pf, output int pa, output int pe, output int pg);
        logic [DW-1:0] m [DP];
        logic [DW-1:0] g;
        for (int i = 0; i < DP; i++) m[i] = mem[i];
        pf = 0; pa = 0; pe = 0; pg = 0;
        for (int ph = 0; ph < 5; ph++) begin
            for (int i = 0; i < blen(ph); i++) m[AW'(i) & ~am] = ew(ph, i);
            for (int i = 0; i < blen(ph); i++) begin
                g = (m[i] | s1) & ~s0;
                if (!pf && g != ew(ph, i)) begin
                    pf = 1; pa = i; pe = int'(ew(ph, i)); pg = int'(g);
                end
            end
        end
    endtask

    // Start a run; optionally pulse start again mid-run
    task automatic run(input int busy_pulse_at, output int edges);
        @(negedge clk);
        start = 1'b1;
        logclr = 1'b1;
        @(negedge clk);
        start = 1'b0;
        logclr = 1'b0;
        check(fail == 1'b0 && fail_addr == '0, "R11 clear at start", int'(fail), 0);
        edges = 0;
        while (!done && edges < 1000) begin
            @(posedge clk);
            #1;
            edges++;
            start = (edges == busy_pulse_at);
        end
        start = 1'b0;
    endtask

    task automatic fault_run(input string tag);
        bit pf;
        int pa, pe, pg, e;
        predict(pf, pa, pe, pg);
        run(0, e);
        check(e == RUN_EDGES, {tag, " R10 run length"}, e, RUN_EDGES);
        check(fail == pf, {tag, " R9 fail flag"}, int'(fail), int'(pf));
        check(int'(fail_addr) == pa, {tag, " R9 fail address"}, int'(fail_addr), pa);
        check(int'(fail_exp) == pe, {tag, " R8 expected word"}, int'(fail_exp), pe);
        check(int'(fail_got) == pg, {tag, " R8 returned word"}, int'(fail_got), pg);
    endtask

    task automatic clean_run(input int busy_at);
        int e, n;
        run(busy_at, e);
        check(e == RUN_EDGES, "R10 run length", e, RUN_EDGES);
        check(fail == 1'b0, "R8 R9 clean run no fail", int'(fail), 0);
        check(wn == 72, "R7 write count", wn, 72);
        check(rn == 72, "R7 read count", rn, 72);
        n = 0;
        for (int ph = 0; ph < 5; ph++) begin
            for (int i = 0; i < blen(ph); i++) begin
                check(int'(wa[n]) == i, {ptag(ph), " write address"}, int'(wa[n]), i);
                check(wd[n] == ew(ph, i), {ptag(ph), " write word"}, int'(wd[n]), int'(ew(ph, i)));
                check(int'(ra[n]) == i, "R7 read address order", int'(ra[n]), i);
                n++;
            end
        end
        for (int a = 0; a < DP; a++)
            check(mem[a] == DW'(a ^ (a >> 1)), "R6 final contents", int'(mem[a]), a ^ (a >> 1));
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            #1;
            check(done == 1'b1, "R10 done held", int'(done), 1);
        end
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!done && !fail && !mem_we && !mem_re, "R1 outputs in reset",
              int'({done, fail, mem_we, mem_re}), 0);
        check(fail_addr == '0 && fail_exp == '0 && fail_got == '0, "R1 record in reset",
              int'(fail_exp), 0);
        @(negedge clk);
        rst = 1'b0;

        clean_run(0);
        clean_run(30);   // R10: start pulse inside the run is ignored

        for (int b = 0; b < DW; b++) begin
            s1 = DW'(1) << b;
            fault_run("R9 stuck-1");
        end
        s1 = '0;
        for (int b = 0; b < DW; b++) begin
            s0 = DW'(1) << b;
            fault_run("R9 stuck-0");
        end
        s0 = '0;
        for (int b = 0; b < AW; b++) begin
            am = AW'(1) << b;
            fault_run("R9 alias");
        end
        am = '0;

        clean_run(0);    // R11: previous failure cleared by the new start

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule